// File: doc/BRIEF.md
# Read-Modify-Write Memory Cycle Unit

This unit carries out a locked read-modify-write on one memory byte for eight operations: arithmetic shift left, logical shift right, rotate left, rotate right, increment, decrement, test-and-set-bits and test-and-reset-bits. A caller presents an effective address, an operation select and the accumulator and carry values, then pulses `start`. The unit reads the operand, spends one internal cycle forming the result, and writes the result back to the same address. It also returns new status flags together with a mask that says which flags the operation updates.

An active-low lock output tells an external bus arbiter not to hand the bus to another master between the modify cycle and the write cycle. A ready input stalls the unit in whatever cycle it is in, write cycles included, so slow memory or a DMA engine can stretch any cycle.

The controller has four states. IDLE waits for `start` (IDLE→READ). READ drives the address with read/write high and captures `rd_data` when `rdy` is high (READ→MODIFY). MODIFY keeps read/write high, asserts the lock and latches the result and flags when `rdy` is high (MODIFY→WRITE). WRITE drives `wr_data` with read/write low and the lock held, and returns to IDLE when `rdy` is high (WRITE→IDLE). While `rdy` is low, every state except IDLE stays where it is.

Top module: `rmw_seq_unit`

## Requirements
- R1: `op_sel` picks the operation: 0 shift left, 1 shift right, 2 rotate left, 3 rotate right, 4 increment, 5 decrement, 6 test-and-set (memory OR accumulator), 7 test-and-reset (memory AND NOT accumulator). `wr_data` carries that result in the write cycle.
- R2: With `rdy` high, the clock edge that sees `start` in IDLE begins a read cycle. The modify cycle and the write cycle follow on the next two edges, each one clock long, and the unit then returns to IDLE.
- R3: `lock_n` is low during the modify and write cycles. It is high during the read cycle and whenever the unit is idle.
- R4: `rw_n` is high in the read and modify cycles and in IDLE. It is low only in the write cycle. `bus_addr` equals the effective address captured at `start` in all three cycles.
- R5: While `rdy` is low in a read, modify or write cycle, the state, `bus_addr`, `rw_n` and `lock_n` hold. The sequence resumes at the first clock edge with `rdy` high.
- R6: Shifts and rotates update N (bit 7 of the result), Z (result zero) and C (the bit shifted out). Rotates shift `carry_in` into the vacated bit. Shifts put a zero in the vacated bit.
- R7: Increment and decrement update only N and Z. Test-and-set and test-and-reset update only Z, which is set when the original memory value AND the accumulator is zero. `flag_upd` is {N,Z,C}, with bit 2 for N, and it is valid while `done` is high.
- R8: `done` is high for exactly the cycle in which a write cycle completes, meaning the write state with `rdy` high, and low at all other times.
- R9: `start` is ignored outside IDLE. Address, operation, accumulator and carry are sampled only when a sequence begins.
- R10: After reset the unit is idle with `lock_n` high, `rw_n` high and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (sampled in IDLE only) |
| op_sel | input | 3 | Operation select |
| eff_addr | input | AW | Effective address of the operand |
| acc_val | input | DW | Accumulator value for bit test operations |
| carry_in | input | 1 | Incoming carry for rotates |
| rdy | input | 1 | Ready; low stalls the current cycle |
| rd_data | input | DW | Memory read data |
| bus_addr | output | AW | Memory address |
| wr_data | output | DW | Memory write data |
| rw_n | output | 1 | High read, low write |
| lock_n | output | 1 | Active-low bus lock |
| done | output | 1 | Write cycle completing |
| flag_n | output | 1 | New negative flag |
| flag_z | output | 1 | New zero flag |
| flag_c | output | 1 | New carry flag |
| flag_upd | output | 3 | Flags updated {N,Z,C}, valid with done |

## Verification
A wrong state register shows at the ports within one clock. `lock_n` separates READ from MODIFY, and `rw_n` separates MODIFY from WRITE, so a skipped or repeated state changes the cycle in which either line moves, and it also shifts `done` by a clock. A wrong captured operand or a wrong result register shows as a bad `wr_data` or bad flags in the write cycle of that same sequence. A stall that is not honoured shows as `done` arriving early, or as `bus_addr`, `rw_n` or `lock_n` changing while `rdy` is low.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    typedef enum logic [2:0] {
        OP_ASL = 3'd0,
        OP_LSR = 3'd1,
        OP_ROL = 3'd2,
        OP_ROR = 3'd3,
        OP_INC = 3'd4,
        OP_DEC = 3'd5,
        OP_TSB = 3'd6,
        OP_TRB = 3'd7
    } rmw_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_MODIFY = 2'd2,
        ST_WRITE  = 2'd3
    } rmw_state_e;

    // flag mask bit positions {N,Z,C}
    localparam int FLG_N = 2;
    localparam int FLG_Z = 1;
    localparam int FLG_C = 0;

endpackage

// File: rtl/rmw_alu.sv
module rmw_alu
    import rmw_pkg::*;
#(
    parameter int DW = 8
) (
    input  rmw_op_e         op,
    input  logic [DW-1:0]   mem,
    input  logic [DW-1:0]   acc,
    input  logic            cin,
    output logic [DW-1:0]   res,
    output logic            n_o,
    output logic            z_o,
    output logic            c_o,
    output logic [2:0]      upd_o
);

    logic bit_test;

    always_comb begin
        res      = mem;
        c_o      = cin;
        upd_o    = 3'b111;
        bit_test = 1'b0;
        unique case (op)
            OP_ASL: {c_o, res} = {mem, 1'b0};
            OP_LSR: {res, c_o} = {1'b0, mem};
            OP_ROL: {c_o, res} = {mem, cin};
            OP_ROR: {res, c_o} = {cin, mem};
            OP_INC: begin
                res   = mem + DW'(1);
                upd_o = 3'b110;
            end
            OP_DEC: begin
                res   = mem - DW'(1);
                upd_o = 3'b110;
            end
            OP_TSB: begin
                res      = mem | acc;
                upd_o    = 3'b010;
                bit_test = 1'b1;
            end
            OP_TRB: begin
                res      = mem & ~acc;
                upd_o    = 3'b010;
                bit_test = 1'b1;
            end
        endcase
        n_o = res[DW-1];
        z_o = bit_test ? ((mem & acc) == '0) : (res == '0);
    end

endmodule

// File: rtl/rmw_fsm.sv
module rmw_fsm
    import rmw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        rdy,
    output rmw_state_e  state,
    output logic        load_en,
    output logic        cap_mem,
    output logic        cap_res,
    output logic        rw_n,
    output logic        lock_n,
    output logic        done
);

    rmw_state_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_READ;
            ST_READ:   if (rdy)   state_nx = ST_MODIFY;
            ST_MODIFY: if (rdy)   state_nx = ST_WRITE;
            ST_WRITE:  if (rdy)   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load_en = 1'b0;
        cap_mem = 1'b0;
        cap_res = 1'b0;
        rw_n    = 1'b1;
        lock_n  = 1'b1;
        done    = 1'b0;
        unique case (state)
            ST_IDLE:   load_en = start;
            ST_READ:   cap_mem = rdy;
            ST_MODIFY: begin
                lock_n  = 1'b0;
                cap_res = rdy;
            end
            ST_WRITE: begin
                lock_n = 1'b0;
                rw_n   = 1'b0;
                done   = rdy;
            end
        endcase
    end

    // R2: leaving the read cycle always lands in modify
    assert_read_then_modify_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && rdy) |=> (state == ST_MODIFY));

endmodule

// File: rtl/rmw_seq_unit.sv
module rmw_seq_unit
    import rmw_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op_sel,
    input  logic [AW-1:0] eff_addr,
    input  logic [DW-1:0] acc_val,
    input  logic          carry_in,
    input  logic          rdy,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] wr_data,
    output logic          rw_n,
    output logic          lock_n,
    output logic          done,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_c,
    output logic [2:0]    flag_upd
);

    rmw_state_e    state;
    logic          load_en, cap_mem, cap_res;
    logic [AW-1:0] ea_q;
    rmw_op_e       op_q;
    logic [DW-1:0] acc_q, mem_q, res_q;
    logic          cin_q;
    logic [DW-1:0] alu_res;
    logic          alu_n, alu_z, alu_c;
    logic [2:0]    alu_upd, upd_q;
    logic          n_q, z_q, c_q;

    rmw_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .rdy     (rdy),
        .state   (state),
        .load_en (load_en),
        .cap_mem (cap_mem),
        .cap_res (cap_res),
        .rw_n    (rw_n),
        .lock_n  (lock_n),
        .done    (done)
    );

    rmw_alu #(.DW(DW)) u_alu (
        .op    (op_q),
        .mem   (mem_q),
        .acc   (acc_q),
        .cin   (cin_q),
        .res   (alu_res),
        .n_o   (alu_n),
        .z_o   (alu_z),
        .c_o   (alu_c),
        .upd_o (alu_upd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q  <= '0;
            op_q  <= OP_ASL;
            acc_q <= '0;
            cin_q <= 1'b0;
        end else if (load_en) begin
            ea_q  <= eff_addr;
            op_q  <= rmw_op_e'(op_sel);
            acc_q <= acc_val;
            cin_q <= carry_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       mem_q <= '0;
        else if (cap_mem) mem_q <= rd_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            n_q   <= 1'b0;
            z_q   <= 1'b0;
            c_q   <= 1'b0;
            upd_q <= '0;
        end else if (cap_res) begin
            res_q <= alu_res;
            n_q   <= alu_n;
            z_q   <= alu_z;
            c_q   <= alu_c;
            upd_q <= alu_upd;
        end
    end

    assign bus_addr = ea_q;
    assign wr_data  = res_q;
    assign flag_n   = n_q;
    assign flag_z   = z_q;
    assign flag_c   = c_q;
    assign flag_upd = done ? upd_q : 3'b000;

    // R3 / R4: a write never happens without the bus lock
    assert_write_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rw_n |-> !lock_n);

    // R4: the lock is taken while the bus is still reading (modify cycle)
    assert_lock_taken_in_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n) |-> rw_n);

    // R5: a stalled cycle keeps address and control lines still
    assert_stall_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !rdy) |=> ($stable(bus_addr) && $stable(rw_n) && $stable(lock_n)));

    // R8: done only with the write strobe
    assert_done_in_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rw_n && rdy));

    // R3 / R8: bus released right after completion
    assert_unlock_after_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (lock_n && rw_n && !done));

endmodule

// File: tb/rmw_seq_unit_test.sv
module rmw_seq_unit_test;

    localparam int AW = 16;
    localparam int DW = 8;

    typedef struct packed {
        logic [2:0] op;
        logic [7:0] mem;
        logic [7:0] acc;
        logic       cin;
        logic [7:0] res;
        logic [2:0] flg;   // {N,Z,C}
        logic [2:0] upd;   // {N,Z,C}
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{3'd0, 8'h81, 8'h00, 1'b0, 8'h02, 3'b001, 3'b111},
        '{3'd1, 8'h01, 8'h00, 1'b0, 8'h00, 3'b011, 3'b111},
        '{3'd2, 8'h40, 8'h00, 1'b1, 8'h81, 3'b100, 3'b111},
        '{3'd3, 8'h02, 8'h00, 1'b1, 8'h81, 3'b100, 3'b111},
        '{3'd4, 8'hFF, 8'h00, 1'b1, 8'h00, 3'b010, 3'b110},
        '{3'd5, 8'h00, 8'h00, 1'b0, 8'hFF, 3'b100, 3'b110},
        '{3'd6, 8'h0F, 8'hF0, 1'b0, 8'hFF, 3'b010, 3'b010},
        '{3'd7, 8'hFF, 8'h0F, 1'b0, 8'hF0, 3'b000, 3'b010},
        '{3'd0, 8'h40, 8'h00, 1'b1, 8'h80, 3'b100, 3'b111},
        '{3'd3, 8'h01, 8'h00, 1'b0, 8'h00, 3'b011, 3'b111},
        '{3'd6, 8'hC3, 8'h81, 1'b0, 8'hC3, 3'b000, 3'b010},
        '{3'd7, 8'hC3, 8'h81, 1'b0, 8'h42, 3'b000, 3'b010},
        '{3'd1, 8'h80, 8'h00, 1'b1, 8'h40, 3'b000, 3'b111}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [2:0]    op_sel = '0;
    logic [AW-1:0] eff_addr = '0;
    logic [DW-1:0] acc_val = '0;
    logic          carry_in = 1'b0;
    logic          rdy = 1'b1;
    logic [DW-1:0] rd_data = '0;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] wr_data;
    logic          rw_n, lock_n, done, flag_n, flag_z, flag_c;
    logic [2:0]    flag_upd;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rmw_seq_unit #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .eff_addr(eff_addr), .acc_val(acc_val), .carry_in(carry_in),
        .rdy(rdy), .rd_data(rd_data), .bus_addr(bus_addr), .wr_data(wr_data),
        .rw_n(rw_n), .lock_n(lock_n), .done(done), .flag_n(flag_n),
        .flag_z(flag_z), .flag_c(flag_c), .flag_upd(flag_upd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        tick(); tick();
        chk("R10 lock_n", 32'(lock_n), 1);
        chk("R10 rw_n", 32'(rw_n), 1);
        chk("R10 done", 32'(done), 0);
        rst_n = 1'b1;
        tick();
        chk("R10 idle lock_n", 32'(lock_n), 1);

        // table walk: R1 R2 R3 R4 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            op_sel   = TBL[i].op;
            acc_val  = TBL[i].acc;
            carry_in = TBL[i].cin;
            rd_data  = TBL[i].mem;
            eff_addr = 16'h1200 + 16'(i * 3);
            start    = 1'b1;
            tick();
            start = 1'b0;
            chk("R3 read lock_n", 32'(lock_n), 1);
            chk("R4 read rw_n", 32'(rw_n), 1);
            chk("R4 read addr", 32'(bus_addr), 32'(16'h1200 + 16'(i * 3)));
            chk("R8 read done", 32'(done), 0);
            tick();
            chk("R3 modify lock_n", 32'(lock_n), 0);
            chk("R4 modify rw_n", 32'(rw_n), 1);
            tick();
            chk("R2 write rw_n", 32'(rw_n), 0);
            chk("R3 write lock_n", 32'(lock_n), 0);
            chk("R8 write done", 32'(done), 1);
            chk("R1 wr_data", 32'(wr_data), 32'(TBL[i].res));
            chk("R7 flag_upd", 32'(flag_upd), 32'(TBL[i].upd));
            chk("R6 flags", 32'({flag_n, flag_z, flag_c} & TBL[i].upd),
                32'(TBL[i].flg & TBL[i].upd));
            tick();
            chk("R2 back to idle lock_n", 32'(lock_n), 1);
            chk("R8 idle done", 32'(done), 0);
            chk("R7 upd cleared", 32'(flag_upd), 0);
        end

        // R5: stalls in read, modify and write (test-and-reset of 0x3C with 0x0C)
        op_sel = 3'd7; acc_val = 8'h0C; rd_data = 8'h3C; eff_addr = 16'hBEEF;
        rdy = 1'b0; start = 1'b1;
        tick();
        start = 1'b0;
        tick(); tick();
        chk("R5 read stall lock_n", 32'(lock_n), 1);
        chk("R5 read stall addr", 32'(bus_addr), 32'h0000BEEF);
        rdy = 1'b1;
        tick();
        chk("R5 resume to modify lock_n", 32'(lock_n), 0);
        rdy = 1'b0;
        tick(); tick();
        chk("R5 modify stall rw_n", 32'(rw_n), 1);
        chk("R5 modify stall lock_n", 32'(lock_n), 0);
        rdy = 1'b1;
        tick();
        rdy = 1'b0;
        #1;
        chk("R5 write stall rw_n", 32'(rw_n), 0);
        chk("R5 write stall done", 32'(done), 0);
        tick(); tick();
        chk("R5 write held rw_n", 32'(rw_n), 0);
        chk("R5 write held lock_n", 32'(lock_n), 0);
        chk("R5 write held addr", 32'(bus_addr), 32'h0000BEEF);
        chk("R7 trb data", 32'(wr_data), 32'h30);
        rdy = 1'b1;
        #1;
        chk("R8 done after stall", 32'(done), 1);
        chk("R7 trb z", 32'(flag_z), 0);
        tick();
        chk("R5 idle after write", 32'(lock_n), 1);

        // R9: start ignored while busy, operands sampled at start only
        op_sel = 3'd4; rd_data = 8'h10; eff_addr = 16'h0042; start = 1'b1;
        tick();
        start = 1'b0;
        tick();
        eff_addr = 16'h9999; op_sel = 3'd5; start = 1'b1;
        tick();
        start = 1'b0;
        chk("R9 addr kept", 32'(bus_addr), 32'h00000042);
        chk("R9 op kept", 32'(wr_data), 32'h11);
        chk("R9 in write", 32'(done), 1);
        tick();
        chk("R9 idle lock_n", 32'(lock_n), 1);
        tick();
        chk("R9 no restart lock_n", 32'(lock_n), 1);
        chk("R9 no restart rw_n", 32'(rw_n), 1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule